// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Source Select

Several pads of a clock generator have two jobs. While power-on reset holds, they are configuration straps: each pad either has a strap resistor pulling it to a level or is left open, and an internal pull-up then makes it read high. This block samples the resolved strap levels on every system clock edge while reset is in effect and keeps the last sample. Once reset has been released through a synchronizer, the block stops sampling and turns the pads into clock outputs.

From the held straps the block builds the live configuration. It registers a 3-bit frequency code and an SDRAM-follow flag, taken either from the straps or from a software configuration byte under one control bit. It also passes on the SIO-rate and CPU-voltage selections and the desktop/mobile mode. The mode decides whether four shared pins stay as power-management inputs or are driven as extra SDRAM clock outputs.

Top module: `strap_cfg_top`

## Requirements
- R1: A strap pad whose `pad_drv` bit is 0 resolves to 1 (pull-up). A pad whose `pad_drv` bit is 1 resolves to its `pad_lvl` bit.
- R2: `strap_q` takes the resolved pad levels on every clock edge while the synchronized reset is active. With the default two synchronizer stages, this includes the second rising edge after `por_n` rises. Strap bit positions: 0 = FS0, 1 = FS1, 2 = FS2, 3 = SDRAM-follow, 4 = mode (1 desktop, 0 mobile), 5 = CPU voltage (1 = 2.5 V), 6 = SIO rate (1 = 24 MHz).
- R3: After that edge, `strap_q` holds its value whatever the pads do, until `por_n` is asserted again.
- R4: `pad_oe` is all zeros while `por_n` is low and on every edge where straps are sampled. It clears asynchronously when `por_n` falls. It becomes all ones on the third rising edge after `por_n` rises.
- R5: When `swcfg[3]` is 0, `fs_code` and `sdram_follow` come from strap bits 2:0 and 3. When `swcfg[3]` is 1, `fs_code` = {`swcfg[6]`,`swcfg[5]`,`swcfg[4]`} and `sdram_follow` = `swcfg[2]`. The other `swcfg` bits have no effect.
- R6: `fs_code` and `sdram_follow` are 0 while `por_n` is low. Afterwards they are registered: a change of source or value shows after exactly one rising edge. The first valid value appears on the third edge after `por_n` rises.
- R7: With the mode strap held at 0 (mobile), `pm_oe` equals `pad_oe` on all four pins. With it held at 1 (desktop), `pm_oe` stays 0.
- R8: `sio_24m` equals held strap bit 6, and `cpu_2v5` equals held strap bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_drv | input | 7 | Per strap pad: 1 when a strap resistor sets the level |
| pad_lvl | input | 7 | Per strap pad: level set by the resistor |
| swcfg | input | 8 | Software configuration byte |
| strap_q | output | 7 | Held strap values |
| pad_oe | output | 7 | Output enable of the shared strap pads |
| pm_oe | output | 4 | Output enable of the mode-dependent pins |
| fs_code | output | 3 | Effective frequency-select code |
| sdram_follow | output | 1 | Effective SDRAM-follows-CPU flag |
| sio_24m | output | 1 | SIO runs at 24 MHz when 1 |
| cpu_2v5 | output | 1 | CPU buffers set for 2.5 V when 1 |

## Verification
The last strap sample and the first edge on which nothing is sampled sit on adjacent edges, and the registered code takes its first load in the same cycle that the output enables rise. The bench changes the pad levels between the first and second edge after release, and checks that the change is captured while `pad_oe` is still low. It then changes the pads again after the enables rise and checks that nothing moves. In one vector the software source bit is already set across the release, and the first registered code is checked against the software fields rather than the straps.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int N_STRAP    = 7;
  localparam int N_FS       = 3;
  localparam int N_PM       = 4;
  localparam int SW_W       = 8;
  // strap bit positions
  localparam int ST_FS0     = 0;
  localparam int ST_FOLLOW  = 3;
  localparam int ST_MODE    = 4;
  localparam int ST_CPUV    = 5;
  localparam int ST_SIO     = 6;
  // software byte positions
  localparam int SW_FOLLOW  = 2;
  localparam int SW_SRC     = 3;
  localparam int SW_FS0     = 4;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               cap_en,
  input  logic [N_STRAP-1:0] pad_drv,
  input  logic [N_STRAP-1:0] pad_lvl,
  output logic [N_STRAP-1:0] strap_q
);
  logic [N_STRAP-1:0] pad_res;
  logic [N_STRAP-1:0] strap_d;

  // pull-up resolution per pad
  for (genvar i = 0; i < N_STRAP; i++) begin : g_pad
    assign pad_res[i] = pad_drv[i] ? pad_lvl[i] : 1'b1;
  end

  always_comb begin
    strap_d = strap_q;
    if (cap_en) strap_d = pad_res;
  end

  // capture registers carry no reset: they are loaded during reset
  always_ff @(posedge clk) begin
    strap_q <= strap_d;
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !cap_en |=> $stable(strap_q)) else $error("strap changed after capture"); // R3
endmodule

// File: rtl/strap_oe_ctl.sv
module strap_oe_ctl
  import strap_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_sync_n,
  input  logic               mode_desk,
  output logic [N_STRAP-1:0] pad_oe,
  output logic [N_PM-1:0]    pm_oe
);
  logic oe_q;
  logic oe_d;

  always_comb begin
    oe_d = rst_sync_n;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  for (genvar i = 0; i < N_STRAP; i++) begin : g_pad_oe
    assign pad_oe[i] = oe_q;
  end
  for (genvar j = 0; j < N_PM; j++) begin : g_pm_oe
    assign pm_oe[j] = oe_q & ~mode_desk;
  end

  AST_DESK_PM_IN: assert property (@(posedge clk) disable iff (!por_n)
    mode_desk |-> pm_oe == '0) else $error("pm pin driven in desktop mode"); // R7
  AST_OE_IN_RESET: assert property (@(posedge clk)
    !por_n |-> pad_oe == '0) else $error("pad driven during reset"); // R4
endmodule

// File: rtl/strap_freq_sel.sv
module strap_freq_sel
  import strap_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic            run,
  input  logic [N_FS-1:0] strap_fs,
  input  logic            strap_follow,
  input  logic            sw_src,
  input  logic [N_FS-1:0] sw_fs,
  input  logic            sw_follow,
  output logic [N_FS-1:0] fs_code,
  output logic            sdram_follow
);
  logic [N_FS-1:0] fs_d;
  logic            follow_d;

  always_comb begin
    fs_d     = fs_code;
    follow_d = sdram_follow;
    if (run) begin
      fs_d     = sw_src ? sw_fs     : strap_fs;
      follow_d = sw_src ? sw_follow : strap_follow;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fs_code      <= '0;
      sdram_follow <= 1'b0;
    end else begin
      fs_code      <= fs_d;
      sdram_follow <= follow_d;
    end
  end

  AST_SW_SOURCE: assert property (@(posedge clk) disable iff (!run)
    sw_src |=> fs_code == $past(sw_fs)) else $error("sw code not taken"); // R5
  AST_STRAP_SOURCE: assert property (@(posedge clk) disable iff (!run)
    !sw_src |=> sdram_follow == $past(strap_follow)) else $error("strap follow not taken"); // R5
  AST_CODE_RESET: assert property (@(posedge clk)
    !por_n |-> (fs_code == '0 && !sdram_follow)) else $error("code not cleared"); // R6
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_STRAP-1:0] pad_drv,
  input  logic [N_STRAP-1:0] pad_lvl,
  input  logic [SW_W-1:0]    swcfg,
  output logic [N_STRAP-1:0] strap_q,
  output logic [N_STRAP-1:0] pad_oe,
  output logic [N_PM-1:0]    pm_oe,
  output logic [N_FS-1:0]    fs_code,
  output logic               sdram_follow,
  output logic               sio_24m,
  output logic               cpu_2v5
);
  logic rst_sync_n;
  logic cap_en;
  logic unused_sw_bits;

  assign cap_en         = ~rst_sync_n;
  assign unused_sw_bits = ^{swcfg[SW_W-1], swcfg[1:0]};

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .por_n      (por_n),
    .rst_sync_n (rst_sync_n)
  );

  strap_sampler u_samp (
    .clk     (clk),
    .por_n   (por_n),
    .cap_en  (cap_en),
    .pad_drv (pad_drv),
    .pad_lvl (pad_lvl),
    .strap_q (strap_q)
  );

  strap_oe_ctl u_oe (
    .clk        (clk),
    .por_n      (por_n),
    .rst_sync_n (rst_sync_n),
    .mode_desk  (strap_q[ST_MODE]),
    .pad_oe     (pad_oe),
    .pm_oe      (pm_oe)
  );

  strap_freq_sel u_fsel (
    .clk          (clk),
    .por_n        (por_n),
    .run          (rst_sync_n),
    .strap_fs     (strap_q[ST_FS0 +: N_FS]),
    .strap_follow (strap_q[ST_FOLLOW]),
    .sw_src       (swcfg[SW_SRC]),
    .sw_fs        (swcfg[SW_FS0 +: N_FS]),
    .sw_follow    (swcfg[SW_FOLLOW]),
    .fs_code      (fs_code),
    .sdram_follow (sdram_follow)
  );

  assign sio_24m = strap_q[ST_SIO];
  assign cpu_2v5 = strap_q[ST_CPUV];

  AST_NO_DRIVE_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!por_n)
    cap_en |-> pad_oe == '0) else $error("pad driven while sampled"); // R4
endmodule

// File: tb/sim_strap_cfg_top.sv
module sim_strap_cfg_top;
  logic       clk = 1'b0;
  logic       por_n;
  logic [6:0] pad_drv, pad_lvl, strap_q, pad_oe;
  logic [7:0] swcfg;
  logic [3:0] pm_oe;
  logic [2:0] fs_code;
  logic       sdram_follow, sio_24m, cpu_2v5;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strap_cfg_top u0 (.clk(clk), .por_n(por_n), .pad_drv(pad_drv), .pad_lvl(pad_lvl),
    .swcfg(swcfg), .strap_q(strap_q), .pad_oe(pad_oe), .pm_oe(pm_oe), .fs_code(fs_code),
    .sdram_follow(sdram_follow), .sio_24m(sio_24m), .cpu_2v5(cpu_2v5));

  // {drv, lvl, swcfg, expected strap, expected code, expected follow}
  localparam logic [32:0] VEC [6] = '{
    {7'h7F, 7'h00, 8'h00, 7'h00, 3'd0, 1'b0},
    {7'h00, 7'h00, 8'h00, 7'h7F, 3'd7, 1'b1},
    {7'h7F, 7'h2D, 8'h00, 7'h2D, 3'd5, 1'b1},
    {7'h7F, 7'h2D, 8'h08, 7'h2D, 3'd0, 1'b0},
    {7'h7F, 7'h00, 8'h6C, 7'h00, 3'd6, 1'b1},
    {7'h0F, 7'h0A, 8'h74, 7'h7A, 3'd2, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_reset(input logic [6:0] d, input logic [6:0] l, input logic [7:0] s);
    @(negedge clk);
    por_n = 1'b0; pad_drv = d; pad_lvl = l; swcfg = s;
    tick(); tick(); tick();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; pad_drv = '0; pad_lvl = '0; swcfg = '0;
    // reset state
    tick(); tick();
    chk("R4 reset oe", {25'd0, pad_oe}, 32'h0);
    chk("R6 reset code", {28'd0, fs_code, sdram_follow}, 32'h0);

    // vector walk
    for (int v = 0; v < 6; v++) begin
      logic [6:0] es;
      enter_reset(VEC[v][32:26], VEC[v][25:19], VEC[v][18:11]);
      es = VEC[v][10:4];
      por_n = 1'b1;
      tick(); tick(); tick();
      chk("R1 R2 strap", {25'd0, strap_q}, {25'd0, es});
      chk("R4 oe up", {25'd0, pad_oe}, 32'h7F);
      chk("R5 code", {28'd0, fs_code, sdram_follow}, {28'd0, VEC[v][3:1], VEC[v][0]});
      chk("R7 pm oe", {28'd0, pm_oe}, es[4] ? 32'h0 : 32'hF);
      chk("R8 sio cpu", {30'd0, sio_24m, cpu_2v5}, {30'd0, es[6], es[5]});
    end

    // R2/R4: pad change between first and second edge after release is captured
    enter_reset(7'h7F, 7'h00, 8'h00);
    por_n = 1'b1;
    tick();
    chk("R4 oe edge1", {25'd0, pad_oe}, 32'h0);
    pad_lvl = 7'h55;
    tick();
    chk("R4 oe edge2", {25'd0, pad_oe}, 32'h0);
    chk("R2 late capture", {25'd0, strap_q}, 32'h55);
    tick();
    chk("R4 oe edge3", {25'd0, pad_oe}, 32'h7F);
    chk("R6 first load", {28'd0, fs_code, sdram_follow}, {28'd0, 3'd5, 1'b0});

    // R3: pads ignored after release
    pad_lvl = 7'h2A; pad_drv = 7'h00;
    tick(); tick();
    chk("R3 hold", {25'd0, strap_q}, 32'h55);
    chk("R8 hold", {30'd0, sio_24m, cpu_2v5}, {30'd0, 1'b1, 1'b0});

    // R6 latency and R5 live source switch
    swcfg = 8'h38;
    chk("R6 before edge", {28'd0, fs_code, sdram_follow}, {28'd0, 3'd5, 1'b0});
    tick();
    chk("R6 after edge", {28'd0, fs_code, sdram_follow}, {28'd0, 3'd3, 1'b0});
    swcfg = 8'hC7;  // source bit off, unrelated bits set
    tick();
    chk("R5 back to straps", {28'd0, fs_code, sdram_follow}, {28'd0, 3'd5, 1'b0});

    // R4/R6: asynchronous clear when reset reasserts mid-cycle
    #5 por_n = 1'b0;
    #1;
    chk("R4 async clear", {25'd0, pad_oe}, 32'h0);
    chk("R6 async clear", {28'd0, fs_code, sdram_follow}, 32'h0);
    tick();
    chk("R2 resample", {25'd0, strap_q}, 32'h7F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule